// File: doc/BRIEF.md
# Predicated Dual-Chain Writeback Selector

This block sits at the register file write side of a SIMD floating-point datapath. The datapath can run two independent short operation chains at the same time. One chain computes the "then" side of a branch and the other computes the "else" side. Each chain delivers a full result vector, one word per lane, together with a destination register index and a valid bit. Both sides of the branch finish together, so the two paths do not have to run one after the other.

For every lane, a predicate mask bit decides which of the two results is committed. A mask bit of 1 takes the "then" result and a mask bit of 0 takes the "else" result. The block then drives that lane's register file write enable, write address and write data. The two sides may target different registers. If only one side is valid, the block acts as a plain masked writeback for that side. All outputs are registered, so a commit appears one clock after its inputs.

Top module: `dcw_writeback_top`

## Requirements
- R1: While reset is asserted, and on the first clock edge after reset, every lane's write enable is 0 and its address and data outputs are 0.
- R2: A lane whose mask bit is 1 while the "then" side is valid writes the "then" lane word to the "then" destination index on the next cycle.
- R3: A lane whose mask bit is 0 while the "else" side is valid writes the "else" lane word to the "else" destination index on the next cycle.
- R4: A lane whose mask bit selects a side that is not valid does not write (write enable 0), even if the other side is valid.
- R5: When neither side is valid, no lane writes.
- R6: The two sides may carry different destination indices, and each lane's address output is the index of the side it commits.
- R7: When both sides name the same destination index, each lane still produces exactly one write, carrying the data of the side its mask bit selects.
- R8: Outputs change only on a clock edge. Between edges they keep the result of the inputs sampled at the previous edge.
- R9: A lane that does not write drives 0 on its address and data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mask | input | LANES | Per-lane predicate; 1 selects "then", 0 selects "else" |
| then_valid | input | 1 | "Then" chain result is valid this cycle |
| then_dst | input | REG_AW | "Then" destination register index |
| then_data | input | LANES*DATA_W | "Then" result words; lane l occupies bits [l*DATA_W +: DATA_W] |
| else_valid | input | 1 | "Else" chain result is valid this cycle |
| else_dst | input | REG_AW | "Else" destination register index |
| else_data | input | LANES*DATA_W | "Else" result words, packed the same way as then_data |
| wr_en | output | LANES | Per-lane register file write enable |
| wr_addr | output | LANES*REG_AW | Per-lane write index; lane l at [l*REG_AW +: REG_AW] |
| wr_data | output | LANES*DATA_W | Per-lane write data; lane l at [l*DATA_W +: DATA_W] |

## Verification
The bench builds the block with 4 lanes, 8-bit words and 2-bit register indices. This makes the full input space of the selection logic small enough to sweep exhaustively. The sweep covers all 16 masks, all four combinations of the two valid bits, and every pairing of the two destination indices, including every case where both indices are equal. Lane data is a distinct arithmetic function of the lane and case number, so a wrong side or a swapped lane shows up as a data mismatch. Each case is also checked once before its clock edge to confirm that the outputs still hold the previous result.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic {
        SIDE_ELSE = 1'b0,
        SIDE_THEN = 1'b1
    } side_e;

    function automatic side_e side_of(input logic mask_bit);
        return mask_bit ? SIDE_THEN : SIDE_ELSE;
    endfunction

endpackage

// File: rtl/dcw_lane_pick.sv
module dcw_lane_pick
    import dcw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              mask_bit,
    input  logic              then_valid,
    input  logic [REG_AW-1:0] then_dst,
    input  logic [DATA_W-1:0] then_word,
    input  logic              else_valid,
    input  logic [REG_AW-1:0] else_dst,
    input  logic [DATA_W-1:0] else_word,
    output logic              pick_we,
    output logic [REG_AW-1:0] pick_addr,
    output logic [DATA_W-1:0] pick_word
);

    side_e side;

    always_comb begin
        side      = side_of(mask_bit);
        pick_we   = 1'b0;
        pick_addr = '0;
        pick_word = '0;
        unique case (side)
            SIDE_THEN: if (then_valid) begin
                pick_we   = 1'b1;
                pick_addr = then_dst;
                pick_word = then_word;
            end
            SIDE_ELSE: if (else_valid) begin
                pick_we   = 1'b1;
                pick_addr = else_dst;
                pick_word = else_word;
            end
            default: pick_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcw_commit_stage.sv
module dcw_commit_stage #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        pick_we,
    input  logic [LANES*REG_AW-1:0] pick_addr,
    input  logic [LANES*DATA_W-1:0] pick_word,
    output logic [LANES-1:0]        wr_en,
    output logic [LANES*REG_AW-1:0] wr_addr,
    output logic [LANES*DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [LANES-1:0]        we;
        logic [LANES*REG_AW-1:0] addr;
        logic [LANES*DATA_W-1:0] word;
    } wb_state_t;

    wb_state_t state_d, state_q;

    always_comb begin
        state_d.we   = pick_we;
        state_d.addr = pick_addr;
        state_d.word = pick_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_en   = state_q.we;
    assign wr_addr = state_q.addr;
    assign wr_data = state_q.word;

endmodule

// File: rtl/dcw_writeback_top.sv
module dcw_writeback_top #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    then_valid,
    input  logic [REG_AW-1:0]       then_dst,
    input  logic [LANES*DATA_W-1:0] then_data,
    input  logic                    else_valid,
    input  logic [REG_AW-1:0]       else_dst,
    input  logic [LANES*DATA_W-1:0] else_data,
    output logic [LANES-1:0]        wr_en,
    output logic [LANES*REG_AW-1:0] wr_addr,
    output logic [LANES*DATA_W-1:0] wr_data
);

    localparam int ADDR_BITS = LANES * REG_AW;
    localparam int DATA_BITS = LANES * DATA_W;

    logic [LANES-1:0]     pick_we;
    logic [ADDR_BITS-1:0] pick_addr;
    logic [DATA_BITS-1:0] pick_word;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dcw_lane_pick #(
            .DATA_W(DATA_W),
            .REG_AW(REG_AW)
        ) u_pick (
            .mask_bit  (lane_mask[l]),
            .then_valid(then_valid),
            .then_dst  (then_dst),
            .then_word (then_data[l*DATA_W +: DATA_W]),
            .else_valid(else_valid),
            .else_dst  (else_dst),
            .else_word (else_data[l*DATA_W +: DATA_W]),
            .pick_we   (pick_we[l]),
            .pick_addr (pick_addr[l*REG_AW +: REG_AW]),
            .pick_word (pick_word[l*DATA_W +: DATA_W])
        );
    end

    dcw_commit_stage #(
        .LANES (LANES),
        .DATA_W(DATA_W),
        .REG_AW(REG_AW)
    ) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick_we  (pick_we),
        .pick_addr(pick_addr),
        .pick_word(pick_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // R1: a cycle spent in reset leaves no write enable set
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (wr_en == '0));

    // R2: every lane masked toward a valid "then" side commits
    assert_then_lanes_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        then_valid |=> ((wr_en & $past(lane_mask)) == $past(lane_mask)));

    // R3: every lane masked toward a valid "else" side commits
    assert_else_lanes_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        else_valid |=> ((wr_en & ~$past(lane_mask)) == ~$past(lane_mask)));

    // R4: lanes pointing at an invalid "then" side stay silent
    assert_invalid_then_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !then_valid |=> ((wr_en & $past(lane_mask)) == '0));

    // R4: lanes pointing at an invalid "else" side stay silent
    assert_invalid_else_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !else_valid |=> ((wr_en & ~$past(lane_mask)) == '0));

    // R5: no valid side means no write anywhere
    assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!then_valid && !else_valid) |=> (wr_en == '0));

    // R7: both sides valid means every lane writes exactly once
    assert_full_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (then_valid && else_valid) |=> ($countones(wr_en) == LANES));

endmodule

// File: tb/tb_dcw_writeback_top.sv
module tb_dcw_writeback_top;

    localparam int LANES  = 4;
    localparam int DATA_W = 8;
    localparam int REG_AW = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        lane_mask = '0;
    logic                    then_valid = 1'b0;
    logic [REG_AW-1:0]       then_dst = '0;
    logic [LANES*DATA_W-1:0] then_data = '0;
    logic                    else_valid = 1'b0;
    logic [REG_AW-1:0]       else_dst = '0;
    logic [LANES*DATA_W-1:0] else_data = '0;
    logic [LANES-1:0]        wr_en;
    logic [LANES*REG_AW-1:0] wr_addr;
    logic [LANES*DATA_W-1:0] wr_data;

    int checks = 0;
    int failures = 0;

    logic [LANES-1:0]        exp_en = '0;
    logic [LANES*REG_AW-1:0] exp_addr = '0;
    logic [LANES*DATA_W-1:0] exp_data = '0;

    always #4 clk = ~clk;

    dcw_writeback_top #(
        .LANES (LANES),
        .DATA_W(DATA_W),
        .REG_AW(REG_AW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_mask (lane_mask),
        .then_valid(then_valid),
        .then_dst  (then_dst),
        .then_data (then_data),
        .else_valid(else_valid),
        .else_dst  (else_dst),
        .else_data (else_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    task automatic check_all(input string req);
        checks++;
        if (wr_en !== exp_en || wr_addr !== exp_addr || wr_data !== exp_data) begin
            failures++;
            $display("FAIL %s: en=%b addr=%h data=%h expected en=%b addr=%h data=%h",
                     req, wr_en, wr_addr, wr_data, exp_en, exp_addr, exp_data);
        end
    endtask

    function automatic string req_tag(input logic m, input logic tv, input logic ev,
                                      input logic [REG_AW-1:0] td, input logic [REG_AW-1:0] ed);
        if (!tv && !ev)        return "R5";
        if (m && !tv)          return "R4";
        if (!m && !ev)         return "R4";
        if (tv && ev && td == ed) return "R7";
        if (tv && ev)          return "R6";
        return m ? "R2" : "R3";
    endfunction

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: outputs cleared while reset is held
        exp_en = '0; exp_addr = '0; exp_data = '0;
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        for (int k = 0; k < 1024; k++) begin
            logic [LANES-1:0]  m;
            logic              tv, ev;
            logic [REG_AW-1:0] td, ed;
            m  = LANES'(k & 15);
            tv = k[4];
            ev = k[5];
            td = REG_AW'((k >> 6) & 3);
            ed = REG_AW'((k >> 8) & 3);
            lane_mask  = m;
            then_valid = tv;
            else_valid = ev;
            then_dst   = td;
            else_dst   = ed;
            for (int l = 0; l < LANES; l++) begin
                then_data[l*DATA_W +: DATA_W] = DATA_W'(l * 37 + k * 3 + 1);
                else_data[l*DATA_W +: DATA_W] = DATA_W'(l * 53 + k * 7 + 5);
            end
            // R8: before the edge the previous result is still held
            #1;
            check_all("R8");
            @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                logic sel_ok;
                sel_ok = m[l] ? tv : ev;
                exp_en[l] = sel_ok;
                exp_addr[l*REG_AW +: REG_AW] = sel_ok ? (m[l] ? td : ed) : '0;
                exp_data[l*DATA_W +: DATA_W] = !sel_ok ? '0 :
                    (m[l] ? DATA_W'(l * 37 + k * 3 + 1) : DATA_W'(l * 53 + k * 7 + 5));
                // R9 covered by the zero expectation on silent lanes
                checks++;
                if (wr_en[l] !== exp_en[l] ||
                    wr_addr[l*REG_AW +: REG_AW] !== exp_addr[l*REG_AW +: REG_AW] ||
                    wr_data[l*DATA_W +: DATA_W] !== exp_data[l*DATA_W +: DATA_W]) begin
                    failures++;
                    $display("FAIL %s lane %0d case %0d: en=%b addr=%h data=%h expected en=%b addr=%h data=%h",
                             req_tag(m[l], tv, ev, td, ed), l, k, wr_en[l],
                             wr_addr[l*REG_AW +: REG_AW], wr_data[l*DATA_W +: DATA_W],
                             exp_en[l], exp_addr[l*REG_AW +: REG_AW], exp_data[l*DATA_W +: DATA_W]);
                end
            end
        end

        // R1: reset mid-stream clears pending writes
        rst_n = 1'b0;
        #1;
        exp_en = '0; exp_addr = '0; exp_data = '0;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        then_valid = 1'b0;
        else_valid = 1'b0;
        @(negedge clk);
        // R5: idle after reset stays silent
        check_all("R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule